// File: doc/BRIEF.md
# Virtualization Instruction Trap Checker

This block rules on privileged instructions for a core that runs guests under a hypervisor. Each cycle the core may present one instruction class along with the current privilege level, the virtualization flag and the relevant trap-control bits from the machine and hypervisor status registers. The block answers in the same cycle: the instruction either executes, raises an illegal-instruction exception, or raises a virtual-instruction exception. For a supervisor return that executes, it also reports the privilege level and virtualization state that control passes to.

A wait-for-interrupt issued by a guest supervisor while the hypervisor wfi-trap bit is set is not trapped at once. The block arms a down-counter loaded from the parameter `WFI_DELAY` and raises a one-cycle delayed virtual trap when the count runs out. A pending interrupt cancels it first. With `WFI_DELAY` set to 0 the virtual trap is raised in the same cycle as the instruction.

Top module: `vtrap_check`

## Requirements
- R1: Class encoding on `insn_class`: 0 wait-for-interrupt, 1 supervisor return, 2 address-translation fence, 3 translation invalidate, 4 address-translation CSR access, 5 hypervisor load/store, 6 hypervisor guest fence, 7 invalidation-ordering fence. Privilege encoding on `cur_priv`: 0 user, 1 supervisor, 3 machine; `cur_virt` marks a virtual mode. At most one of `res_exec`, `res_illegal` and `res_virtual` is high, and all three are low when `insn_valid` is low.
- R2: In machine mode every class executes.
- R3: With `m_tw` set, a wait-for-interrupt raises an illegal-instruction exception in every mode below machine, including virtual-user. Illegal takes priority over virtual.
- R4: With `m_tw` clear, a wait-for-interrupt executes in hypervisor-supervisor mode, is illegal in user mode, and raises a virtual-instruction exception in virtual-user mode.
- R5: With `m_tw` clear, a wait-for-interrupt in virtual-supervisor mode executes when `h_vtw` is clear. When `h_vtw` is set and `WFI_DELAY` > 0, it gives no immediate result and sets `wfi_armed` from the next clock edge.
- R6: Once armed, `wfi_vtrap` is high for exactly one cycle: the cycle after the `WFI_DELAY`-th rising edge that follows the presenting cycle. `wfi_armed` falls on the following edge.
- R7: An armed delay is cancelled when `irq_pending` is high. `wfi_vtrap` stays low, and `wfi_armed` falls on the next edge.
- R8: A supervisor return is illegal in user mode and raises a virtual-instruction exception in virtual-user mode. In virtual-supervisor mode it raises a virtual-instruction exception when `h_vtsr` is set. Otherwise it executes with `ret_virt`=1 and `ret_priv` equal to 1 if `prev_spp` is set and 0 if it is clear.
- R9: A supervisor return in hypervisor-supervisor or machine mode executes with `ret_virt` equal to `h_spv` and `ret_priv` equal to 1 when `prev_spp` is set, 0 otherwise. `ret_priv` and `ret_virt` are 0 in every other case.
- R10: Classes 2, 3 and 4 in virtual-supervisor mode raise a virtual-instruction exception when `h_vtvm` is set and execute when it is clear; `m_tvm` has no effect there. In hypervisor-supervisor mode they are illegal when `m_tvm` is set and execute otherwise.
- R11: Classes 2, 3, 4, 6 and 7 are illegal in user mode. Classes 2, 3 and 4 raise a virtual-instruction exception in virtual-user mode.
- R12: Class 6 executes in hypervisor-supervisor mode and raises a virtual-instruction exception in both virtual modes. Class 7 executes in hypervisor-supervisor and virtual-supervisor modes whatever `h_vtvm` is, and raises a virtual-instruction exception in virtual-user mode.
- R13: Class 5 is illegal in user mode unless `h_hu` is set, in which case it executes. It executes in hypervisor-supervisor mode and raises a virtual-instruction exception in both virtual modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | An instruction is presented this cycle |
| insn_class | input | 3 | Instruction class |
| cur_priv | input | 2 | Current privilege level |
| cur_virt | input | 1 | Current mode is virtual |
| m_tw | input | 1 | Machine wfi-trap control |
| m_tvm | input | 1 | Machine trap-translation control |
| h_vtw | input | 1 | Hypervisor guest wfi-trap control |
| h_vtsr | input | 1 | Hypervisor guest return-trap control |
| h_vtvm | input | 1 | Hypervisor guest trap-translation control |
| h_hu | input | 1 | Allow hypervisor load/store in user mode |
| h_spv | input | 1 | Previous virtualization state |
| prev_spp | input | 1 | Previous privilege (1 supervisor, 0 user) |
| irq_pending | input | 1 | An interrupt is pending |
| res_exec | output | 1 | Instruction executes |
| res_illegal | output | 1 | Illegal-instruction exception |
| res_virtual | output | 1 | Virtual-instruction exception |
| wfi_armed | output | 1 | Delayed guest wfi trap is counting |
| wfi_vtrap | output | 1 | Delayed virtual-instruction exception pulse |
| ret_priv | output | 2 | Privilege after an executing supervisor return |
| ret_virt | output | 1 | Virtualization after an executing supervisor return |

## Verification
The assertions take for granted that `cur_priv` never carries the reserved value 2 and that machine mode is never flagged virtual. They also assume the core presents no new instruction while `wfi_armed` is high, because it is stalled on the wait. The bench keeps to these rules. It drives only the three legal privilege values and leaves `cur_virt` low in machine mode. In the delay scenarios it holds `insn_valid` for a single cycle and leaves it low until the counter has fired or been cancelled.

// File: rtl/vtrap_check.sv
module vtrap_check #(
  parameter int WFI_DELAY = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       insn_valid,
  input  logic [2:0] insn_class,
  input  logic [1:0] cur_priv,
  input  logic       cur_virt,
  input  logic       m_tw,
  input  logic       m_tvm,
  input  logic       h_vtw,
  input  logic       h_vtsr,
  input  logic       h_vtvm,
  input  logic       h_hu,
  input  logic       h_spv,
  input  logic       prev_spp,
  input  logic       irq_pending,
  output logic       res_exec,
  output logic       res_illegal,
  output logic       res_virtual,
  output logic       wfi_armed,
  output logic       wfi_vtrap,
  output logic [1:0] ret_priv,
  output logic       ret_virt
);

  localparam bit DLY_EN = (WFI_DELAY > 0);
  localparam int CW = DLY_EN ? $clog2(WFI_DELAY + 1) : 1;

  localparam logic [2:0] C_WFI   = 3'd0;
  localparam logic [2:0] C_SRET  = 3'd1;
  localparam logic [2:0] C_FVMA  = 3'd2;
  localparam logic [2:0] C_IVMA  = 3'd3;
  localparam logic [2:0] C_ATP   = 3'd4;
  localparam logic [2:0] C_HLSV  = 3'd5;
  localparam logic [2:0] C_HFNC  = 3'd6;
  localparam logic [2:0] C_ORD   = 3'd7;

  localparam logic [1:0] K_EXEC = 2'd0;
  localparam logic [1:0] K_ILL  = 2'd1;
  localparam logic [1:0] K_VIRT = 2'd2;
  localparam logic [1:0] K_DLY  = 2'd3;

  logic          is_m, is_hs, is_u, is_vs, is_vu;
  logic [1:0]    kind;
  logic          busy;
  logic [CW-1:0] cnt;
  logic          start, fire;

  assign is_m  = (cur_priv == 2'b11);
  assign is_hs = (cur_priv == 2'b01) && !cur_virt;
  assign is_u  = (cur_priv == 2'b00) && !cur_virt;
  assign is_vs = (cur_priv == 2'b01) && cur_virt;
  assign is_vu = (cur_priv == 2'b00) && cur_virt;

  always_comb begin
    kind = K_EXEC;
    if (!is_m) begin
      case (insn_class)
        C_WFI: begin
          if (m_tw || is_u)      kind = K_ILL;
          else if (is_vu)        kind = K_VIRT;
          else if (is_vs && h_vtw) kind = DLY_EN ? K_DLY : K_VIRT;
        end
        C_SRET: begin
          if (is_u)                      kind = K_ILL;
          else if (is_vu || (is_vs && h_vtsr)) kind = K_VIRT;
        end
        C_FVMA, C_IVMA, C_ATP: begin
          if (is_u || (is_hs && m_tvm))        kind = K_ILL;
          else if (is_vu || (is_vs && h_vtvm)) kind = K_VIRT;
        end
        C_HLSV: begin
          if (is_u && !h_hu) kind = K_ILL;
          else if (cur_virt) kind = K_VIRT;
        end
        C_HFNC: begin
          if (is_u)          kind = K_ILL;
          else if (cur_virt) kind = K_VIRT;
        end
        default: begin
          if (is_u)       kind = K_ILL;
          else if (is_vu) kind = K_VIRT;
        end
      endcase
    end
  end

  assign res_exec    = insn_valid && (kind == K_EXEC);
  assign res_illegal = insn_valid && (kind == K_ILL);
  assign res_virtual = insn_valid && (kind == K_VIRT);

  logic sret_ok;
  assign sret_ok  = res_exec && (insn_class == C_SRET);
  assign ret_virt = sret_ok && (cur_virt || h_spv);
  assign ret_priv = {1'b0, sret_ok && prev_spp};

  assign start     = insn_valid && (kind == K_DLY);
  assign fire      = busy && (cnt == '0) && !irq_pending;
  assign wfi_armed = busy;
  assign wfi_vtrap = fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CW'(WFI_DELAY);
    end else if (busy) begin
      if (irq_pending || cnt == '0) busy <= 1'b0;
      else                          cnt  <= cnt - 1'b1;
    end
  end

  a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({res_exec, res_illegal, res_virtual}));

  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |-> !(res_exec || res_illegal || res_virtual));

  a_r2_machine_exec: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid && is_m |-> res_exec);

  a_r3_tw_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid && insn_class == C_WFI && m_tw && !is_m |-> res_illegal);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wfi_vtrap |=> !wfi_vtrap && !wfi_armed);

  a_r7_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    wfi_armed && irq_pending && !start |=> !wfi_armed);

  a_r9_ret_target: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid && insn_class == C_SRET && (is_hs || is_m) |-> ret_virt == h_spv && ret_priv[0] == prev_spp);

  a_r10_vtvm_virtual: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid && is_vs && h_vtvm && (insn_class == C_FVMA || insn_class == C_IVMA || insn_class == C_ATP)
      |-> res_virtual);

endmodule

// File: tb/vtrap_check_test.sv
module vtrap_check_test;
  localparam int CLK_PERIOD = 10;
  localparam int DLY = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic insn_valid = 1'b0;
  logic [2:0] insn_class = 3'd0;
  logic [1:0] cur_priv = 2'd0;
  logic cur_virt = 1'b0;
  logic m_tw = 0, m_tvm = 0, h_vtw = 0, h_vtsr = 0, h_vtvm = 0, h_hu = 0, h_spv = 0, prev_spp = 0;
  logic irq_pending = 1'b0;
  logic res_exec, res_illegal, res_virtual, wfi_armed, wfi_vtrap, ret_virt;
  logic [1:0] ret_priv;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  vtrap_check #(.WFI_DELAY(DLY)) uut (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_class(insn_class),
    .cur_priv(cur_priv), .cur_virt(cur_virt), .m_tw(m_tw), .m_tvm(m_tvm),
    .h_vtw(h_vtw), .h_vtsr(h_vtsr), .h_vtvm(h_vtvm), .h_hu(h_hu), .h_spv(h_spv),
    .prev_spp(prev_spp), .irq_pending(irq_pending), .res_exec(res_exec),
    .res_illegal(res_illegal), .res_virtual(res_virtual), .wfi_armed(wfi_armed),
    .wfi_vtrap(wfi_vtrap), .ret_priv(ret_priv), .ret_virt(ret_virt));

  always #(CLK_PERIOD/2) clk = ~clk;

  localparam logic [2:0] EX = 3'b100, IL = 3'b010, VI = 3'b001, NO = 3'b000;
  localparam logic [1:0] PU = 2'd0, PS = 2'd1, PM = 2'd3;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic probe(input string req, input logic [2:0] c, input logic [1:0] p,
                       input logic v, input logic [2:0] exp);
    @(negedge clk);
    insn_class = c; cur_priv = p; cur_virt = v; insn_valid = 1'b1;
    #1;
    check(req, {5'd0, res_exec, res_illegal, res_virtual}, {5'd0, exp});
    insn_valid = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    check("R1 reset outputs", {3'd0, res_exec, res_illegal, res_virtual, wfi_armed, wfi_vtrap}, 8'd0);
  endtask

  task automatic t_machine;
    m_tw = 1; m_tvm = 1; h_vtsr = 1; h_vtvm = 1;
    for (int c = 0; c < 8; c++) probe("R2 machine exec", 3'(c), PM, 1'b0, EX);
    m_tw = 0; m_tvm = 0; h_vtsr = 0; h_vtvm = 0;
  endtask

  task automatic t_wfi_mtw;
    m_tw = 1; h_vtw = 1;
    probe("R3 tw hs", 3'd0, PS, 1'b0, IL);
    probe("R3 tw u", 3'd0, PU, 1'b0, IL);
    probe("R3 tw vs", 3'd0, PS, 1'b1, IL);
    probe("R3 tw vu priority", 3'd0, PU, 1'b1, IL);
    check("R3 no arm", {7'd0, wfi_armed}, 8'd0);
    m_tw = 0; h_vtw = 0;
  endtask

  task automatic t_wfi_plain;
    probe("R4 wfi hs", 3'd0, PS, 1'b0, EX);
    probe("R4 wfi u", 3'd0, PU, 1'b0, IL);
    probe("R4 wfi vu", 3'd0, PU, 1'b1, VI);
    probe("R5 wfi vs vtw clear", 3'd0, PS, 1'b1, EX);
    check("R5 no arm", {7'd0, wfi_armed}, 8'd0);
  endtask

  task automatic arm;
    h_vtw = 1;
    @(negedge clk);
    insn_class = 3'd0; cur_priv = PS; cur_virt = 1'b1; insn_valid = 1'b1;
    #1;
    check("R5 no immediate result", {5'd0, res_exec, res_illegal, res_virtual}, 8'd0);
    @(negedge clk);
    insn_valid = 1'b0; h_vtw = 0;
    check("R5 armed", {6'd0, wfi_armed, wfi_vtrap}, 8'b10);
  endtask

  task automatic t_timer;
    arm();
    for (int k = 1; k < DLY; k++) begin
      @(negedge clk);
      check("R6 not yet", {6'd0, wfi_armed, wfi_vtrap}, 8'b10);
    end
    @(negedge clk);
    check("R6 fire", {6'd0, wfi_armed, wfi_vtrap}, 8'b11);
    @(negedge clk);
    check("R6 disarm", {6'd0, wfi_armed, wfi_vtrap}, 8'b00);
  endtask

  task automatic t_cancel;
    arm();
    @(negedge clk);
    irq_pending = 1'b1;
    #1;
    check("R7 gated", {7'd0, wfi_vtrap}, 8'd0);
    @(negedge clk);
    irq_pending = 1'b0;
    check("R7 disarmed", {6'd0, wfi_armed, wfi_vtrap}, 8'b00);
    for (int k = 0; k < DLY + 1; k++) begin
      @(negedge clk);
      check("R7 no late trap", {6'd0, wfi_armed, wfi_vtrap}, 8'b00);
    end
  endtask

  task automatic t_sret;
    probe("R8 sret u", 3'd1, PU, 1'b0, IL);
    probe("R8 sret vu", 3'd1, PU, 1'b1, VI);
    h_vtsr = 1;
    probe("R8 sret vs vtsr", 3'd1, PS, 1'b1, VI);
    h_vtsr = 0;
    for (int s = 0; s < 2; s++) begin
      prev_spp = s[0]; h_spv = 1'b0;
      @(negedge clk);
      insn_class = 3'd1; cur_priv = PS; cur_virt = 1'b1; insn_valid = 1'b1;
      #1;
      check("R8 sret vs target", {3'd0, res_exec, ret_priv, ret_virt, 1'b0},
            {3'd0, 1'b1, 1'b0, s[0], 1'b1, 1'b0});
      insn_valid = 1'b0;
    end
    for (int s = 0; s < 8; s++) begin
      prev_spp = s[0]; h_spv = s[1];
      @(negedge clk);
      insn_class = 3'd1; cur_priv = s[2] ? PM : PS; cur_virt = 1'b0; insn_valid = 1'b1;
      #1;
      check("R9 sret target", {3'd0, res_exec, ret_priv, ret_virt, 1'b0},
            {3'd0, 1'b1, 1'b0, s[0], s[1], 1'b0});
      insn_valid = 1'b0;
    end
    prev_spp = 1; h_spv = 1;
    @(negedge clk);
    insn_class = 3'd2; cur_priv = PS; cur_virt = 1'b0; insn_valid = 1'b1;
    #1;
    check("R9 no target for other class", {5'd0, ret_priv, ret_virt}, 8'd0);
    insn_valid = 1'b0; prev_spp = 0; h_spv = 0;
  endtask

  task automatic t_tvm;
    for (int c = 2; c <= 4; c++) begin
      h_vtvm = 1; m_tvm = 0;
      probe("R10 vtvm vs", 3'(c), PS, 1'b1, VI);
      h_vtvm = 0; m_tvm = 1;
      probe("R10 mtvm ignored in vs", 3'(c), PS, 1'b1, EX);
      probe("R10 mtvm hs", 3'(c), PS, 1'b0, IL);
      m_tvm = 0;
      probe("R10 hs exec", 3'(c), PS, 1'b0, EX);
      probe("R11 u illegal", 3'(c), PU, 1'b0, IL);
      probe("R11 vu virtual", 3'(c), PU, 1'b1, VI);
    end
  endtask

  task automatic t_guest;
    h_vtvm = 1;
    probe("R12 hfence hs", 3'd6, PS, 1'b0, EX);
    probe("R12 hfence vs", 3'd6, PS, 1'b1, VI);
    probe("R12 hfence vu", 3'd6, PU, 1'b1, VI);
    probe("R11 hfence u", 3'd6, PU, 1'b0, IL);
    probe("R12 order vs vtvm set", 3'd7, PS, 1'b1, EX);
    h_vtvm = 0;
    probe("R12 order vs vtvm clear", 3'd7, PS, 1'b1, EX);
    probe("R12 order hs", 3'd7, PS, 1'b0, EX);
    probe("R12 order vu", 3'd7, PU, 1'b1, VI);
    probe("R11 order u", 3'd7, PU, 1'b0, IL);
  endtask

  task automatic t_hlsv;
    h_hu = 0;
    probe("R13 u no hu", 3'd5, PU, 1'b0, IL);
    h_hu = 1;
    probe("R13 u hu", 3'd5, PU, 1'b0, EX);
    probe("R13 hs", 3'd5, PS, 1'b0, EX);
    probe("R13 vs", 3'd5, PS, 1'b1, VI);
    probe("R13 vu", 3'd5, PU, 1'b1, VI);
    h_hu = 0;
  endtask

  task automatic t_idle;
    @(negedge clk);
    insn_valid = 1'b0; insn_class = 3'd5; cur_priv = PU; cur_virt = 1'b0;
    #1;
    check("R1 idle no result", {5'd0, res_exec, res_illegal, res_virtual}, 8'd0);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    t_idle();
    t_machine();
    t_wfi_mtw();
    t_wfi_plain();
    t_timer();
    t_cancel();
    t_sret();
    t_tvm();
    t_guest();
    t_hlsv();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end
endmodule